// File: doc/BRIEF.md
# Expansion Bus Slave Data-Phase Controller

This block handles the data phase of a slave card on a 32-bit multiplexed expansion bus and connects it to a small local word store. The address phase is decoded elsewhere. It hands the block a held select and a word address. From then on the block answers the master's data output enable, read/write direction and four active-low byte strobes. It drives read data or captures write data, and it gives the transfer acknowledge. Together with its slave-select response it reports whether the card is cacheable, and whether it accepts several transfers within one full cycle.

Writes go into a holding stage and are committed to the store one clock later, so the acknowledge does not wait for the store. Reads wait a fixed, parameterised number of clocks for the store. A strobe group whose asserted lanes are not adjacent is refused for writing and raises an error flag that stays set. The transfer is still acknowledged, so the bus cannot hang.

The controller has five states. `ST_IDLE` moves to `ST_WAIT_STB` when select rises, and the word address is latched on that move. `ST_WAIT_STB` moves to `ST_RD_WAIT` on a read strobe group, or straight to `ST_ACK` on a write. `ST_RD_WAIT` moves to `ST_ACK` when the latency count is reached. `ST_ACK` moves to `ST_GAP` when the master releases the transfer. `ST_GAP` returns to `ST_WAIT_STB` on a new request strobe once the multi-transfer handshake is complete. Any state other than `ST_IDLE` returns to `ST_IDLE` when select drops.

Top module: `xbus_dphase_slave`

## Requirements
- R1: Data output enable is high only while the block acknowledges, the master's data output enable is high and the cycle is a read. At all other times it is low, including during write acknowledges.
- R2: For a write, acknowledge goes low on the first clock edge that samples an asserted strobe group with data output enable high. For a read, it goes low RD_LAT clocks after that edge. For a later word of a multi-transfer cycle, add one clock for the request strobe edge.
- R3: Acknowledge stays low, with the read data stable, until the master releases the transfer. Release means every data strobe is negated, or in multi-transfer mode the request strobe is negated. Acknowledge goes high on the next clock edge after release.
- R4: Strobe bit 3 qualifies data bits 31..24 and strobe bit 0 qualifies bits 7..0. A write stores only the lanes whose strobe is low.
- R5: With CACHEABLE=0, cache inhibit is asserted and read lanes whose strobe is high return zero. With CACHEABLE=1, cache inhibit stays negated and a read returns all four stored bytes.
- R6: Slave select, cache inhibit (when non-cacheable) and multi-transfer acknowledge (when MULTI_OK=1) are asserted on the clock after select rises. All three return high on the clock after select drops. With MULTI_OK=0, multi-transfer acknowledge never asserts.
- R7: Strobe values 2, 4, 5, 6 and 10 (bit 3 down to bit 0) are invalid. A write with an invalid value stores nothing and is still acknowledged.
- R8: An invalid strobe value sets the error output, which stays high until reset.
- R9: If the request strobe is low at the first transfer and MULTI_OK=1, each later fall of the request strobe latches a new word address and starts a new transfer within the same cycle. A slave with MULTI_OK=0 ignores further strobes until select drops.
- R10: After reset, acknowledge, slave select, cache inhibit and multi-transfer acknowledge are high. Data output enable, read data and the error output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Card selected, held for the full cycle |
| addr_i | input | ADDR_W | Word address, sampled when select rises and at each request strobe fall |
| rd_i | input | 1 | 1 = read, 0 = write |
| doe_i | input | 1 | Master's data output enable |
| ds_n_i | input | 4 | Active-low byte strobes, bit 3 = bits 31..24 |
| mtr_n_i | input | 1 | Active-low multi-transfer request strobe |
| data_i | input | 32 | Write data from the bus |
| data_o | output | 32 | Read data to the bus |
| data_oe_o | output | 1 | Enable for the data bus drivers |
| ack_n_o | output | 1 | Active-low transfer acknowledge |
| slvsel_n_o | output | 1 | Active-low slave-select response |
| cinh_n_o | output | 1 | Active-low cache inhibit |
| mtack_n_o | output | 1 | Active-low multi-transfer acknowledge |
| strobe_err_o | output | 1 | Sticky invalid-strobe flag |

## Verification
The bench builds two instances on the same bus. u0 uses CACHEABLE=0, MULTI_OK=1 and RD_LAT=2. u1 uses CACHEABLE=1, MULTI_OK=0 and RD_LAT=3. Running them side by side puts masked and unmasked reads, two read latencies, and the presence and absence of the multi-transfer acknowledge within reach of one stimulus sequence. It also covers a second transfer that u0 must take while u1 stays silent.

// File: rtl/xbus_dp_pkg.sv
package xbus_dp_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_STB,
        ST_RD_WAIT,
        ST_ACK,
        ST_GAP
    } dp_state_e;

    // Asserted lanes (1 = asserted) form one unbroken, non-empty run.
    function automatic logic lanes_adjacent(input logic [LANES-1:0] m);
        int edges;
        edges = int'(m[0]) + int'(m[LANES-1]);
        for (int i = 0; i < LANES - 1; i++) begin
            edges += int'(m[i] != m[i+1]);
        end
        return (m != '0) && (edges == 2);
    endfunction

endpackage

// File: rtl/xbus_lane_chk.sv
module xbus_lane_chk
    import xbus_dp_pkg::*;
(
    input  logic [LANES-1:0]  ds_n_i,
    output logic              any_o,
    output logic              adjacent_o,
    output logic [DATA_W-1:0] bit_mask_o
);
    logic [LANES-1:0] act;

    assign act        = ~ds_n_i;
    assign any_o      = |act;
    assign adjacent_o = lanes_adjacent(act);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_mask_o[g*LANE_W +: LANE_W] = {LANE_W{act[g]}};
    end
endmodule

// File: rtl/xbus_word_store.sv
module xbus_word_store
    import xbus_dp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [LANES-1:0]  wr_lanes_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              hold_vld;
    logic [ADDR_W-1:0] hold_addr;
    logic [LANES-1:0]  hold_lanes;
    logic [DATA_W-1:0] hold_data;

    // Holding stage: the bus side is released before the commit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_vld   <= 1'b0;
            hold_addr  <= '0;
            hold_lanes <= '0;
            hold_data  <= '0;
        end else begin
            hold_vld <= wr_req_i;
            if (wr_req_i) begin
                hold_addr  <= wr_addr_i;
                hold_lanes <= wr_lanes_i;
                hold_data  <= wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (hold_vld) begin
            for (int l = 0; l < LANES; l++) begin
                if (hold_lanes[l]) begin
                    mem[hold_addr][l*LANE_W +: LANE_W] <= hold_data[l*LANE_W +: LANE_W];
                end
            end
        end
        rd_data_o <= mem[rd_addr_i];
    end

    AST_NO_BROKEN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_i |-> lanes_adjacent(wr_lanes_i)); // R7
endmodule

// File: rtl/xbus_dp_fsm.sv
module xbus_dp_fsm
    import xbus_dp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RD_LAT    = 2,
    parameter bit CACHEABLE = 1'b0,
    parameter bit MULTI_OK  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              doe_i,
    input  logic [LANES-1:0]  ds_n_i,
    input  logic              mtr_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              lane_any_i,
    input  logic              lane_ok_i,
    input  logic [DATA_W-1:0] lane_bits_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [LANES-1:0]  wr_lanes_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              ack_n_o,
    output logic              slvsel_n_o,
    output logic              cinh_n_o,
    output logic              mtack_n_o,
    output logic              err_o
);
    localparam int LAT_W = $clog2(RD_LAT + 1);
    localparam logic [LAT_W-1:0] LAT_END = LAT_W'(RD_LAT);

    dp_state_e         state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [LAT_W-1:0]  cnt_q;
    logic              mt_on_q;
    logic              first_q;
    logic              accept;
    logic              release_x;
    logic              next_word;

    assign accept    = doe_i && lane_any_i;
    assign release_x = mt_on_q ? mtr_n_i : !lane_any_i;
    assign next_word = mt_on_q && !mtr_n_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (sel_i)             nxt = ST_WAIT_STB;
            ST_WAIT_STB: if (accept)            nxt = rd_i ? ST_RD_WAIT : ST_ACK;
            ST_RD_WAIT:  if (cnt_q == LAT_END)  nxt = ST_ACK;
            ST_ACK:      if (release_x)         nxt = ST_GAP;
            ST_GAP:      if (next_word)         nxt = ST_WAIT_STB;
            default:                            nxt = ST_IDLE;
        endcase
        if (!sel_i) nxt = ST_IDLE;
    end

    // Outputs
    always_comb begin
        slvsel_n_o = (state == ST_IDLE);
        cinh_n_o   = (state == ST_IDLE) || CACHEABLE;
        mtack_n_o  = (state == ST_IDLE) || !MULTI_OK;
        ack_n_o    = (state != ST_ACK);
        data_oe_o  = (state == ST_ACK) && doe_i && rd_i;
        wr_req_o   = (state == ST_WAIT_STB) && sel_i && accept && !rd_i && lane_ok_i;
        wr_addr_o  = addr_q;
        wr_lanes_o = ~ds_n_i;
        wr_data_o  = data_i;
        rd_addr_o  = addr_q;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            mt_on_q <= 1'b0;
            first_q <= 1'b0;
            data_o  <= '0;
            err_o   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    mt_on_q <= 1'b0;
                    if (sel_i) begin
                        addr_q  <= addr_i;
                        first_q <= 1'b1;
                    end
                end
                ST_WAIT_STB: begin
                    if (accept) begin
                        first_q <= 1'b0;
                        cnt_q   <= LAT_W'(1);
                        if (first_q && MULTI_OK && !mtr_n_i) mt_on_q <= 1'b1;
                        if (!lane_ok_i) err_o <= 1'b1;
                    end
                end
                ST_RD_WAIT: begin
                    if (cnt_q == LAT_END) begin
                        data_o <= CACHEABLE ? rd_data_i : (rd_data_i & lane_bits_i);
                    end else begin
                        cnt_q <= cnt_q + LAT_W'(1);
                    end
                end
                ST_ACK: ;
                ST_GAP: if (next_word && sel_i) addr_q <= addr_i;
                default: ;
            endcase
        end
    end

    AST_RESP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        slvsel_n_o |-> (cinh_n_o && mtack_n_o)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R8
    AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n_o && $past(!ack_n_o)) |-> $stable(data_o)); // R3
endmodule

// File: rtl/xbus_dphase_slave.sv
module xbus_dphase_slave
    import xbus_dp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RD_LAT    = 2,
    parameter bit CACHEABLE = 1'b0,
    parameter bit MULTI_OK  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              doe_i,
    input  logic [3:0]        ds_n_i,
    input  logic              mtr_n_i,
    input  logic [31:0]       data_i,
    output logic [31:0]       data_o,
    output logic              data_oe_o,
    output logic              ack_n_o,
    output logic              slvsel_n_o,
    output logic              cinh_n_o,
    output logic              mtack_n_o,
    output logic              strobe_err_o
);
    logic              lane_any, lane_ok;
    logic [DATA_W-1:0] lane_bits;
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [LANES-1:0]  wr_lanes;
    logic [DATA_W-1:0] wr_data, rd_data;

    xbus_lane_chk u_lanes (
        .ds_n_i     (ds_n_i),
        .any_o      (lane_any),
        .adjacent_o (lane_ok),
        .bit_mask_o (lane_bits)
    );

    xbus_dp_fsm #(
        .ADDR_W    (ADDR_W),
        .RD_LAT    (RD_LAT),
        .CACHEABLE (CACHEABLE),
        .MULTI_OK  (MULTI_OK)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_i),
        .addr_i      (addr_i),
        .rd_i        (rd_i),
        .doe_i       (doe_i),
        .ds_n_i      (ds_n_i),
        .mtr_n_i     (mtr_n_i),
        .data_i      (data_i),
        .lane_any_i  (lane_any),
        .lane_ok_i   (lane_ok),
        .lane_bits_i (lane_bits),
        .rd_data_i   (rd_data),
        .wr_req_o    (wr_req),
        .wr_addr_o   (wr_addr),
        .wr_lanes_o  (wr_lanes),
        .wr_data_o   (wr_data),
        .rd_addr_o   (rd_addr),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o),
        .ack_n_o     (ack_n_o),
        .slvsel_n_o  (slvsel_n_o),
        .cinh_n_o    (cinh_n_o),
        .mtack_n_o   (mtack_n_o),
        .err_o       (strobe_err_o)
    );

    xbus_word_store #(.ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req_i   (wr_req),
        .wr_addr_i  (wr_addr),
        .wr_lanes_i (wr_lanes),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data)
    );

    AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> !ack_n_o); // R1
    AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_o |-> !slvsel_n_o); // R3
endmodule

// File: tb/sim_xbus_dphase_slave.sv
module sim_xbus_dphase_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, rd = 1'b0, doe = 1'b0, mtr_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [3:0]  ds_n = 4'hF;
    logic [31:0] din = '0;
    logic [31:0] dout0, dout1;
    logic        oe0, ack0, sn0, ci0, mt0, er0;
    logic        oe1, ack1, sn1, ci1, mt1, er1;

    int n_chk = 0, n_err = 0;
    logic [31:0] ref0 [256];
    logic [31:0] ref1 [256];
    logic [31:0] q0 [$];
    logic [31:0] q1 [$];

    always #10 clk = ~clk;

    xbus_dphase_slave #(.ADDR_W(8), .RD_LAT(2), .CACHEABLE(1'b0), .MULTI_OK(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .addr_i(addr), .rd_i(rd), .doe_i(doe),
        .ds_n_i(ds_n), .mtr_n_i(mtr_n), .data_i(din), .data_o(dout0), .data_oe_o(oe0),
        .ack_n_o(ack0), .slvsel_n_o(sn0), .cinh_n_o(ci0), .mtack_n_o(mt0), .strobe_err_o(er0));

    xbus_dphase_slave #(.ADDR_W(8), .RD_LAT(3), .CACHEABLE(1'b1), .MULTI_OK(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .addr_i(addr), .rd_i(rd), .doe_i(doe),
        .ds_n_i(ds_n), .mtr_n_i(mtr_n), .data_i(din), .data_o(dout1), .data_oe_o(oe1),
        .ack_n_o(ack1), .slvsel_n_o(sn1), .cinh_n_o(ci1), .mtack_n_o(mt1), .strobe_err_o(er1));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Monitor: pops expected read data on each acknowledge fall
    logic pa0 = 1'b1, pa1 = 1'b1;
    always @(negedge clk) begin
        if (rst_n && rd) begin
            if (pa0 && !ack0) begin
                if (q0.size() == 0) chk("R5", "u0 unexpected read ack", 32'd1, 32'd0);
                else begin
                    chk("R5", "u0 read data", dout0, q0.pop_front());
                    chk("R1", "u0 drivers on at read ack", {31'd0, oe0}, 32'd1);
                end
            end
            if (pa1 && !ack1) begin
                if (q1.size() == 0) chk("R9", "u1 unexpected read ack", 32'd1, 32'd0);
                else chk("R5", "u1 read data", dout1, q1.pop_front());
            end
        end
        pa0 <= ack0;
        pa1 <= ack1;
    end

    task automatic start_cycle(input logic [7:0] a);
        @(negedge clk);
        sel = 1'b1; addr = a;
        @(negedge clk);
        chk("R6", "u0 select/inhibit/mtack", {29'd0, sn0, ci0, mt0}, 32'd0);
        chk("R6", "u1 select/inhibit/mtack", {29'd0, sn1, ci1, mt1}, 32'd3);
    endtask

    task automatic end_cycle();
        @(negedge clk);
        sel = 1'b0; doe = 1'b0; ds_n = 4'hF; mtr_n = 1'b1;
        @(negedge clk);
        chk("R6", "u0 responses negated", {29'd0, sn0, ci0, mt0}, 32'd7);
        chk("R6", "u1 responses negated", {29'd0, sn1, ci1, mt1}, 32'd7);
    endtask

    // Driver: one transfer; pushes expected read data into the scoreboard
    task automatic xfer(input logic [7:0] a, input bit rdw, input logic [3:0] dsn,
                        input logic [31:0] d, input bit mt, input bit want1,
                        input int lat0, input int lat1);
        logic [31:0] m;
        bit pat_ok;
        int g0, g1;
        pat_ok = !(dsn inside {4'd2, 4'd4, 4'd5, 4'd6, 4'd10});
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = dsn[i] ? 8'h00 : 8'hFF;
        if (rdw) begin
            q0.push_back(ref0[a] & m);
            if (want1) q1.push_back(ref1[a]);
        end else if (pat_ok) begin
            ref0[a] = (ref0[a] & ~m) | (d & m);
            if (want1) ref1[a] = (ref1[a] & ~m) | (d & m);
        end
        @(negedge clk);
        addr = a; rd = rdw; doe = 1'b1; ds_n = dsn; din = d; mtr_n = !mt;
        g0 = 0; g1 = 0;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            if (!ack0 && g0 == 0) g0 = n;
            if (!ack1 && g1 == 0) g1 = n;
            if (g0 != 0 && (!want1 || g1 != 0)) break;
        end
        chk("R2", "u0 ack latency", g0, lat0);
        if (want1) chk("R2", "u1 ack latency", g1, lat1);
        else       chk("R9", "u1 ignores extra transfer", g1, 0);
        if (!rdw) chk("R1", "u0 drivers off on write", {31'd0, oe0}, 32'd0);
        @(negedge clk);
        chk("R3", "u0 ack held", {31'd0, ack0}, 32'd0);
        if (rdw) begin
            doe = 1'b0;
            #1;
            chk("R1", "drivers off without doe", {30'd0, oe0, oe1}, 32'd0);
            doe = 1'b1;
        end
        @(negedge clk);
        chk("R3", "u0 ack still held", {31'd0, ack0}, 32'd0);
        ds_n = 4'hF; mtr_n = 1'b1;
        @(negedge clk);
        chk("R3", "u0 ack released", {31'd0, ack0}, 32'd1);
        if (want1) chk("R3", "u1 ack released", {31'd0, ack1}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("R2", "watchdog expired", 32'd1, 32'd0);
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin ref0[i] = '0; ref1[i] = '0; end
        #5;
        chk("R10", "u0 reset outputs", {26'd0, ack0, sn0, ci0, mt0, oe0, er0}, 32'h3C);
        chk("R10", "u0 reset data", dout0, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 R4: full write then full read
        start_cycle(8'd5);
        xfer(8'd5, 1'b0, 4'h0, 32'h11223344, 1'b0, 1'b1, 1, 1);
        end_cycle();
        start_cycle(8'd5);
        xfer(8'd5, 1'b1, 4'h0, 32'h0, 1'b0, 1'b1, 3, 4);
        end_cycle();

        // R4 R5: lower half write, upper half read (u0 masks, u1 returns all)
        start_cycle(8'd5);
        xfer(8'd5, 1'b0, 4'b1100, 32'hAAAABBBB, 1'b0, 1'b1, 1, 1);
        end_cycle();
        start_cycle(8'd5);
        xfer(8'd5, 1'b1, 4'b0011, 32'h0, 1'b0, 1'b1, 3, 4);
        end_cycle();

        // R7 R8: invalid strobe write is acknowledged, discarded, flagged
        start_cycle(8'd5);
        xfer(8'd5, 1'b0, 4'd5, 32'hFFFFFFFF, 1'b0, 1'b1, 1, 1);
        end_cycle();
        chk("R8", "error flags set", {30'd0, er0, er1}, 32'd3);
        start_cycle(8'd5);
        xfer(8'd5, 1'b1, 4'h0, 32'h0, 1'b0, 1'b1, 3, 4);
        end_cycle();

        // R9: multi-transfer writes then reads; u1 only takes the first word
        start_cycle(8'd10);
        xfer(8'd10, 1'b0, 4'h0, 32'hCAFE0001, 1'b1, 1'b1, 1, 1);
        xfer(8'd11, 1'b0, 4'h0, 32'hCAFE0002, 1'b1, 1'b0, 2, 0);
        end_cycle();
        start_cycle(8'd10);
        xfer(8'd10, 1'b1, 4'h0, 32'h0, 1'b1, 1'b1, 3, 4);
        xfer(8'd11, 1'b1, 4'b1000, 32'h0, 1'b1, 1'b0, 4, 0);
        end_cycle();

        chk("R8", "error flags still set", {30'd0, er0, er1}, 32'd3);
        chk("R5", "scoreboard drained", q0.size() + q1.size(), 32'd0);
        summary();
    end
endmodule